// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Registered Flags

This block computes one arithmetic or logic operation per cycle on two 8-bit register operands. The operation covers add, subtract, bitwise and/or/xor, one-bit shifts of the destination operand, multiply, unsigned divide and compare. The result and the destination write-enable come out combinationally. The four condition flags are captured in a register on the clock edge that ends the operation, so conditional branches in the next cycle read a stable flag set.

The destination operand enters on `dst_i` and the source operand on `src_i`. When `valid_i` is high, an opcode from 0 to 9 is executed. Compare produces the same flags as subtract but never asserts the write-enable. Opcodes 10 to 15 belong to other units: this block neither writes back for them nor changes its flags.

Top module: `alu8_flags`

## Requirements
- R1: With `valid_i` high, opcodes 0 to 8 assert `wr_en_o` and drive `result_o` combinationally. The opcode map is 0 add, 1 subtract (dst−src), 2 and, 3 or, 4 xor, 5 shift left, 6 shift right, 7 multiply, 8 divide, 9 compare. With `valid_i` low, `wr_en_o` is 0.
- R2: Add sets C (`flags_o[1]`) on unsigned carry out, so 255+1 gives 0 with C=1. It sets V (`flags_o[3]`) on signed overflow, so 127+1 sets V and 1+1 clears it.
- R3: Subtract and compare set C=1 when dst ≥ src (no borrow) and C=0 otherwise. V is set when the operand signs differ and the result sign differs from dst.
- R4: Compare (opcode 9) never asserts `wr_en_o`. It drives dst−src on `result_o` and updates the flags exactly as subtract does.
- R5: The flag layout is `flags_o` = {V, N, C, Z} (bits 3..0). Z is set when the 8-bit result is zero. N equals result bit 7, so 0−1 gives 0xFF with N=1.
- R6: Shift left and shift right move dst by one bit with zero fill (0x65 shifted left gives 0xCA). C takes the bit shifted out and V is cleared. The operations and, or and xor clear both C and V.
- R7: Multiply writes the low 8 bits of the product (17×9 gives 153). C is set when the upper 8 product bits are non-zero, and V is cleared.
- R8: Divide writes the unsigned quotient (100/7 gives 14) with C=0 and V=0. Divide by zero writes 0xFF, sets V, clears C and takes N and Z from 0xFF.
- R9: Flags reset to 0 while `rst_ni` is low. They update on the rising edge at which a valid opcode 0 to 9 is present and hold on every other edge.
- R10: Opcodes 10 to 15 never assert `wr_en_o`, drive `result_o` to 0 and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; flags update on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the flags |
| valid_i | input | 1 | Operation strobe for this cycle |
| op_i | input | 4 | Opcode |
| dst_i | input | 8 | Destination register operand (first operand) |
| src_i | input | 8 | Source register operand (second operand) |
| result_o | output | 8 | Combinational result |
| wr_en_o | output | 1 | Destination register write-enable |
| flags_o | output | 4 | Registered flags {V, N, C, Z} |

## Verification
The datapath is purely combinational, so a wrong carry or overflow term shows on `flags_o` at the first rising edge after the faulty operation. A wrong decode shows at once on `result_o` or `wr_en_o` in the same cycle. A flag register that updates when it should hold shows only once a later idle or foreign-opcode cycle is compared against the flags left by the previous valid operation. For that reason, idle cycles and opcodes 10 to 15 are placed straight after operations that leave distinctive flag patterns.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2, OP_OR  = 4'd3, OP_XOR = 4'd4,
    OP_SHL = 4'd5, OP_SHR = 4'd6, OP_MUL = 4'd7, OP_DIV = 4'd8, OP_CMP = 4'd9
  } alu_op_e;

  localparam logic [3:0] OP_LAST = 4'd9;

  typedef struct packed {
    logic v;
    logic n;
    logic c;
    logic z;
  } alu_flags_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         v_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   ext;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    // carry out of a + ~b + 1 is the no-borrow indication
    ext   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
    sum_o = ext[W-1:0];
    c_o   = ext[W];
    v_o   = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
  end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         c_o
);
  always_comb begin
    res_o = '0;
    c_o   = 1'b0;
    case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_SHL: begin
        res_o = {a_i[W-2:0], 1'b0};
        c_o   = a_i[W-1];
      end
      OP_SHR: begin
        res_o = {1'b0, a_i[W-1:1]};
        c_o   = a_i[0];
      end
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu8_muldiv.sv
module alu8_muldiv #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         div_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         v_o
);
  localparam int PW = 2 * W;

  logic [PW-1:0] prod;
  logic          div_zero;

  always_comb begin
    prod     = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
    div_zero = (b_i == '0);
    if (div_i) begin
      res_o = div_zero ? '1 : (a_i / b_i);
      c_o   = 1'b0;
      v_o   = div_zero;
    end else begin
      res_o = prod[W-1:0];
      c_o   = |prod[PW-1:W];
      v_o   = 1'b0;
    end
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] dst_i,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic [3:0]   flags_o
);
  logic [W-1:0] as_sum, bit_res, md_res;
  logic         as_c, as_v, bit_c, md_c, md_v;
  logic         is_sub, known_op;
  alu_flags_t   flags_d, flags_q;

  assign is_sub   = (op_i == OP_SUB) || (op_i == OP_CMP);
  assign known_op = (op_i <= OP_LAST);

  alu8_addsub #(.W(W)) u_addsub (
    .a_i(dst_i), .b_i(src_i), .sub_i(is_sub),
    .sum_o(as_sum), .c_o(as_c), .v_o(as_v)
  );

  alu8_bitops #(.W(W)) u_bitops (
    .op_i(op_i), .a_i(dst_i), .b_i(src_i),
    .res_o(bit_res), .c_o(bit_c)
  );

  alu8_muldiv #(.W(W)) u_muldiv (
    .a_i(dst_i), .b_i(src_i), .div_i(op_i == OP_DIV),
    .res_o(md_res), .c_o(md_c), .v_o(md_v)
  );

  always_comb begin
    result_o  = '0;
    flags_d.c = 1'b0;
    flags_d.v = 1'b0;
    case (op_i)
      OP_ADD, OP_SUB, OP_CMP: begin
        result_o  = as_sum;
        flags_d.c = as_c;
        flags_d.v = as_v;
      end
      OP_AND, OP_OR, OP_XOR, OP_SHL, OP_SHR: begin
        result_o  = bit_res;
        flags_d.c = bit_c;
      end
      OP_MUL, OP_DIV: begin
        result_o  = md_res;
        flags_d.c = md_c;
        flags_d.v = md_v;
      end
      default: result_o = '0;
    endcase
    flags_d.z = (result_o == '0);
    flags_d.n = result_o[W-1];
  end

  assign wr_en_o = valid_i && known_op && (op_i != OP_CMP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 flags_q <= '0;
    else if (valid_i && known_op) flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [3:0]   op_i,
  input logic [W-1:0] dst_i,
  input logic [W-1:0] src_i,
  input logic [W-1:0] result_o,
  input logic         wr_en_o,
  input logic [3:0]   flags_o
);
  // R4
  cmp_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd9) |-> !wr_en_o);

  // R2
  add_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd0) |=>
      flags_o[1] == (({1'b0, $past(dst_i)} + {1'b0, $past(src_i)}) > {1'b0, {W{1'b1}}}));

  // R3
  sub_no_borrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 4'd1 || op_i == 4'd9)) |=> flags_o[1] == ($past(dst_i) >= $past(src_i)));

  // R8
  div_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd8 && src_i == '0) |-> (result_o == {W{1'b1}}));

  // R8
  div_zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd8 && src_i == '0) |=> flags_o[3] && !flags_o[1]);

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(flags_o));

  // R10
  foreign_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i > 4'd9) |=> $stable(flags_o));

  // R10
  foreign_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > 4'd9) |-> !wr_en_o);

  // R1
  idle_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !wr_en_o);
endmodule

bind alu8_flags alu8_flags_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .dst_i(dst_i), .src_i(src_i), .result_o(result_o), .wr_en_o(wr_en_o),
  .flags_o(flags_o)
);

// File: tb/tb_alu8_flags.sv
module tb_alu8_flags;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic [7:0] dst_i = 8'd0;
  logic [7:0] src_i = 8'd0;
  logic [7:0] result_o;
  logic       wr_en_o;
  logic [3:0] flags_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [7:0] res;
    logic       wr;
    logic [3:0] flg;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  logic [3:0] model_flg = 4'd0;

  always #5 clk_i = ~clk_i;

  alu8_flags dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .dst_i(dst_i), .src_i(src_i), .result_o(result_o), .wr_en_o(wr_en_o),
    .flags_o(flags_o)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // driver: computes expectation independently and queues it
  task automatic drive(string tag, bit v, int op, int a, int b);
    exp_t e;
    int r, s, c, ov;
    bit upd;
    @(negedge clk_i);
    valid_i = v; op_i = 4'(op); dst_i = 8'(a); src_i = 8'(b);
    r = 0; c = 0; ov = 0; upd = v && (op <= 9);
    case (op)
      0: begin s = a + b; r = s & 255; c = int'(s > 255);
               ov = int'(((a ^ r) & (b ^ r) & 128) != 0); end
      1, 9: begin r = (a - b) & 255; c = int'(a >= b);
               ov = int'(((a ^ b) & (a ^ r) & 128) != 0); end
      2: r = a & b;
      3: r = a | b;
      4: r = a ^ b;
      5: begin r = (a << 1) & 255; c = (a >> 7) & 1; end
      6: begin r = a >> 1; c = a & 1; end
      7: begin s = a * b; r = s & 255; c = int'(s > 255); end
      8: begin if (b == 0) begin r = 255; ov = 1; end else r = a / b; end
      default: r = 0;
    endcase
    if (upd) model_flg = {1'(ov), 1'((r >> 7) & 1), 1'(c), 1'(r == 0)};
    e.res = 8'(r);
    e.wr  = v && (op <= 8);
    e.flg = model_flg;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: result/wr_en still driven by current inputs, flags just updated
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "result", int'(result_o), int'(e.res));
        check(e.tag, "wr_en", int'(wr_en_o), int'(e.wr));
        check(e.tag, "flags", int'(flags_o), int'(e.flg));
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    repeat (2) @(negedge clk_i);
    check("R9", "reset flags", int'(flags_o), 0);
    check("R1", "reset wr_en", int'(wr_en_o), 0);
    rst_ni = 1'b1;
    // R2 add carry / overflow
    drive("R2", 1, 0, 255, 1);
    drive("R2", 1, 0, 127, 1);
    drive("R2", 1, 0, 1, 1);
    // R1 idle must not write, R9 flags hold under junk inputs
    drive("R9", 0, 0, 255, 1);
    // R3 subtract
    drive("R3", 1, 1, 0, 1);
    drive("R5", 1, 1, 5, 5);
    drive("R3", 1, 1, 3, 5);
    drive("R3", 1, 1, 8'h80, 1);
    drive("R3", 1, 1, 1, 8'h80);
    // R4 compare
    drive("R4", 1, 9, 5, 5);
    drive("R4", 1, 9, 5, 3);
    drive("R4", 1, 9, 3, 5);
    // R6 logic and shifts
    drive("R6", 1, 2, 8'hCC, 8'hF0);
    drive("R6", 1, 3, 8'hC0, 8'h0F);
    drive("R6", 1, 4, 8'hCF, 8'hAA);
    drive("R6", 1, 5, 8'h65, 0);
    drive("R6", 1, 5, 8'h80, 0);
    drive("R6", 1, 6, 8'hCA, 0);
    drive("R6", 1, 6, 8'h01, 0);
    drive("R6", 1, 4, 8'h5A, 8'h5A);
    // R7 multiply
    drive("R7", 1, 7, 17, 9);
    drive("R7", 1, 7, 16, 16);
    drive("R7", 1, 7, 200, 3);
    // R8 divide
    drive("R8", 1, 8, 100, 7);
    drive("R8", 1, 8, 0, 5);
    drive("R8", 1, 8, 42, 0);
    // R10 foreign opcodes after distinctive flags
    for (int op = 10; op < 16; op++) drive("R10", 1, op, 8'hFF, 8'h01);
    drive("R2", 1, 0, 8'h80, 8'h80);
    drive("R9", 0, 9, 0, 0);
    drive("R10", 1, 15, 0, 0);
    drive("R1", 1, 0, 20, 22);
    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule